// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor as two request wires: a normal request and a fast request. Software programs it through a small 32-bit register bus. Per source it holds an enable bit, a routing bit and a 4-bit priority, and it can also assert a source in place of the hardware line. Enables can be changed one source at a time by writing the source's number to a set port or a clear port. This spares software a read-modify-write of a shared bitmap.

Sources routed to the normal output take part in a priority contest. The normal vector word reports the winning source and its priority. A 5-bit threshold decides whether that winner actually raises the normal request. Sources routed to the fast output skip priority: the fast vector word reports the highest-numbered pending one.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the control word reads 0, the threshold reads 0x1F, and the enable, routing, force and all eight priority words read 0. Both request outputs are low.
- R2: A write of N (0..63) to offset 0x08 sets enable bit N and leaves the other 63 unchanged. A write of N to offset 0x0C clears enable bit N only.
- R3: A value of 64 or more written to 0x08 or 0x0C leaves every enable bit unchanged. It does not wrap to a lower source number.
- R4: Each 64-bit map is split into a word for sources 32..63 and a word for sources 0..31, with bit k of a word being source 32+k or source k. The pairs are enable at 0x10/0x14, routing at 0x18/0x1C and force at 0x50/0x54, and each is written and read back whole.
- R5: Priorities sit eight per word. Group g (sources 8g..8g+7) is at offset 0x20+4*(7-g), and source s uses bits [(s%8)*4+3 : (s%8)*4].
- R6: A source is active when its line or its force bit is 1. Normal-pending (0x58/0x5C) is active AND enabled AND routing 0. Fast-pending (0x60/0x64) is active AND enabled AND routing 1. The raw lines read at 0x48/0x4C.
- R7: The normal vector at 0x40 holds the winning normal-pending source in [31:16] and its priority in [15:0]. The winner has the highest priority, and on equal priority the higher source number. With no normal-pending source the word reads 0xFFFF_FFFF.
- R8: The fast vector at 0x44 holds the highest-numbered fast-pending source in [31:16] with [15:0] zero. With none pending it reads 0xFFFF_FFFF.
- R9: The threshold at 0x04 is 5 bits wide. The normal request needs a winner and one of the following: a threshold of 0x00..0x0F that is below the winner's priority, or a threshold of 0x10..0x1E. A threshold of 0x1F blocks the request.
- R10: The fast request is high exactly when some source is fast-pending.
- R11: Both requests come from registers: they follow a line or register change one clock later.
- R12: Writes to the read-only words (vectors, raw and pending) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive interrupt lines |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte offset, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the offset |
| irq_norm_o | output | 1 | Registered normal interrupt request |
| irq_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that the interrupt lines and the bus inputs are synchronous to the clock. They also assume that a write lasts exactly the one cycle in which strobe and write are both high, and that offsets are word aligned. The stimulus changes every input on the falling edge only, issues one bus access at a time with only aligned offsets, and releases the strobe before the next access. The enable-change properties can therefore compare the map in consecutive cycles without another write overlapping.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC   = 64;
  localparam int PW     = 4;
  localparam int GRP_SZ = 32 / PW;
  localparam int NGRP   = NSRC / GRP_SZ;
  localparam int IDXW   = $clog2(NSRC);
  localparam int MASKW  = 5;

  // word index = byte offset >> 2
  localparam logic [4:0] W_CTRL   = 5'd0;
  localparam logic [4:0] W_MASK   = 5'd1;
  localparam logic [4:0] W_ENNUM  = 5'd2;
  localparam logic [4:0] W_DISNUM = 5'd3;
  localparam logic [4:0] W_ENH    = 5'd4;
  localparam logic [4:0] W_ENL    = 5'd5;
  localparam logic [4:0] W_TYH    = 5'd6;
  localparam logic [4:0] W_TYL    = 5'd7;
  localparam logic [4:0] W_PRLO   = 5'd8;
  localparam logic [4:0] W_PRHI   = 5'd15;
  localparam logic [4:0] W_NVEC   = 5'd16;
  localparam logic [4:0] W_FVEC   = 5'd17;
  localparam logic [4:0] W_RAWH   = 5'd18;
  localparam logic [4:0] W_RAWL   = 5'd19;
  localparam logic [4:0] W_FRCH   = 5'd20;
  localparam logic [4:0] W_FRCL   = 5'd21;
  localparam logic [4:0] W_NPH    = 5'd22;
  localparam logic [4:0] W_NPL    = 5'd23;
  localparam logic [4:0] W_FPH    = 5'd24;
  localparam logic [4:0] W_FPL    = 5'd25;

  typedef struct packed {
    logic          found;
    logic [2:0]    idx;
    logic [PW-1:0] prio;
  } pick_t;

  // best of eight candidates; later index wins on equal priority
  function automatic pick_t pick8(input logic [7:0] v, input logic [8*PW-1:0] p);
    pick_t r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (v[i] && (!r.found || p[i*PW +: PW] >= r.prio)) begin
        r.found = 1'b1;
        r.idx   = 3'(i);
        r.prio  = p[i*PW +: PW];
      end
    end
    return r;
  endfunction

  function automatic logic mask_pass(input logic [PW-1:0] prio, input logic [MASKW-1:0] mask);
    if (mask == 5'h1F) return 1'b0;
    if (mask[4])       return 1'b1;
    return {1'b0, prio} > mask;
  endfunction

  function automatic logic [31:0] vec_word(input logic found, input logic [IDXW-1:0] idx,
                                           input logic [PW-1:0] prio);
    if (!found) return 32'hFFFF_FFFF;
    return {{(16-IDXW){1'b0}}, idx, {(16-PW){1'b0}}, prio};
  endfunction

  function automatic logic [IDXW-1:0] top_index(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) if (v[i]) r = IDXW'(i);
    return r;
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [4:0]            widx_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           ctrl_o,
  output logic [MASKW-1:0]      mask_o,
  output logic [N_SRC-1:0]      enable_o,
  output logic [N_SRC-1:0]      route_o,
  output logic [N_SRC-1:0]      force_o,
  output logic [N_SRC*PW-1:0]   prio_o
);
  localparam int NG = N_SRC / GRP_SZ;
  localparam int GW = $clog2(NG);

  logic [31:0]         ctrl_q;
  logic [MASKW-1:0]    mask_q;
  logic [N_SRC-1:0]    enable_q, route_q, force_q;
  logic [NG-1:0][31:0] prio_q;

  logic            num_ok, en_set_hit, en_clr_hit, num_bad_hit, prio_hit;
  logic [IDXW-1:0] num_idx;
  logic [GW-1:0]   grp_sel;

  assign num_ok      = wdata_i < 32'(N_SRC);
  assign num_idx     = wdata_i[IDXW-1:0];
  assign en_set_hit  = wr_i && (widx_i == W_ENNUM) && num_ok;
  assign en_clr_hit  = wr_i && (widx_i == W_DISNUM) && num_ok;
  assign num_bad_hit = wr_i && ((widx_i == W_ENNUM) || (widx_i == W_DISNUM)) && !num_ok;
  assign prio_hit    = wr_i && (widx_i >= W_PRLO) && (widx_i <= W_PRHI);
  assign grp_sel     = GW'(W_PRHI - widx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= 5'h1F;
      enable_q <= '0;
      route_q  <= '0;
      force_q  <= '0;
      prio_q   <= '0;
    end else begin
      if (en_set_hit) enable_q[num_idx] <= 1'b1;
      if (en_clr_hit) enable_q[num_idx] <= 1'b0;
      if (prio_hit)   prio_q[grp_sel]   <= wdata_i;
      if (wr_i) begin
        case (widx_i)
          W_CTRL: ctrl_q            <= wdata_i;
          W_MASK: mask_q            <= wdata_i[MASKW-1:0];
          W_ENH:  enable_q[63:32]   <= wdata_i;
          W_ENL:  enable_q[31:0]    <= wdata_i;
          W_TYH:  route_q[63:32]    <= wdata_i;
          W_TYL:  route_q[31:0]     <= wdata_i;
          W_FRCH: force_q[63:32]    <= wdata_i;
          W_FRCL: force_q[31:0]     <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign mask_o   = mask_q;
  assign enable_o = enable_q;
  assign route_o  = route_q;
  assign force_o  = force_q;
  assign prio_o   = prio_q;

  // R2: number write touches its own bit only
  p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_hit |=> enable_q[$past(num_idx)] &&
      ((enable_q ^ $past(enable_q)) & ~(64'd1 << $past(num_idx))) == '0);
  p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_hit |=> !enable_q[$past(num_idx)] &&
      ((enable_q ^ $past(enable_q)) & ~(64'd1 << $past(num_idx))) == '0);
  // R3: out-of-range numbers leave the map alone
  p_num_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    num_bad_hit |=> $stable(enable_q));
endmodule

// File: rtl/pic_norm_arb.sv
module pic_norm_arb
  import pic_pkg::*;
#(
  parameter int N_SRC = NSRC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     pend_i,
  input  logic [N_SRC*PW-1:0]  prio_i,
  output logic                 win_found_o,
  output logic [IDXW-1:0]      win_idx_o,
  output logic [PW-1:0]        win_prio_o
);
  localparam int NG = N_SRC / GRP_SZ;

  logic [NG-1:0]       grp_found;
  logic [NG*PW-1:0]    grp_prio;
  logic [NG-1:0][2:0]  grp_idx;
  pick_t               final_pick;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    pick_t loc;
    assign loc = pick8(pend_i[g*GRP_SZ +: GRP_SZ], prio_i[g*GRP_SZ*PW +: GRP_SZ*PW]);
    assign grp_found[g]          = loc.found;
    assign grp_prio[g*PW +: PW]  = loc.prio;
    assign grp_idx[g]            = loc.idx;
  end

  assign final_pick  = pick8(grp_found, grp_prio);
  assign win_found_o = final_pick.found;
  assign win_idx_o   = {final_pick.idx, grp_idx[final_pick.idx]};
  assign win_prio_o  = final_pick.prio;

  // R7: winner is a pending source; no winner means nothing pending
  p_win_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_found_o |-> pend_i[win_idx_o]);
  p_win_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_found_o |-> (pend_i == '0));
  p_win_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_found_o |-> (prio_i[win_idx_o*PW +: PW] == win_prio_o));
endmodule

// File: rtl/pic_req_out.sv
module pic_req_out
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             norm_found_i,
  input  logic [PW-1:0]    norm_prio_i,
  input  logic [MASKW-1:0] mask_i,
  input  logic             fast_any_i,
  output logic             irq_norm_o,
  output logic             irq_fast_o
);
  logic norm_go;
  assign norm_go = norm_found_i && mask_pass(norm_prio_i, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_norm_o <= 1'b0;
      irq_fast_o <= 1'b0;
    end else begin
      irq_norm_o <= norm_go;
      irq_fast_o <= fast_any_i;
    end
  end

  // R10 / R11: fast request follows pending one cycle later
  p_fast_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fast_any_i |=> irq_fast_o);
  p_fast_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_any_i |=> !irq_fast_o);
  // R9: full threshold or empty contest keeps normal request low
  p_norm_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == 5'h1F) |=> !irq_norm_o);
  p_norm_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_found_i |=> !irq_norm_o);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] src_i,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [6:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        irq_norm_o,
  output logic        irq_fast_o
);
  logic [4:0]           widx;
  logic                 wr;
  logic [31:0]          ctrl;
  logic [MASKW-1:0]     mask;
  logic [NSRC-1:0]      enable, route, frc, active, npend, fpend;
  logic [NSRC*PW-1:0]   prio;
  logic                 win_found;
  logic [IDXW-1:0]      win_idx;
  logic [PW-1:0]        win_prio;
  logic                 fast_any;
  logic [31:0]          nvec, fvec;
  logic [2:0]           rd_grp;

  assign widx = bus_addr_i[6:2];
  assign wr   = bus_sel_i && bus_wr_i;

  pic_regs #(.N_SRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .widx_i(widx), .wdata_i(bus_wdata_i),
    .ctrl_o(ctrl), .mask_o(mask), .enable_o(enable), .route_o(route),
    .force_o(frc), .prio_o(prio)
  );

  assign active = src_i | frc;
  assign npend  = active & enable & ~route;
  assign fpend  = active & enable & route;
  assign fast_any = |fpend;

  pic_norm_arb #(.N_SRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(npend), .prio_i(prio),
    .win_found_o(win_found), .win_idx_o(win_idx), .win_prio_o(win_prio)
  );

  pic_req_out u_req (
    .clk(clk), .rst_n(rst_n), .norm_found_i(win_found), .norm_prio_i(win_prio),
    .mask_i(mask), .fast_any_i(fast_any),
    .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  assign nvec   = vec_word(win_found, win_idx, win_prio);
  assign fvec   = vec_word(fast_any, top_index(fpend), '0);
  assign rd_grp = 3'(W_PRHI - widx);

  always_comb begin
    bus_rdata_o = '0;
    if (widx >= W_PRLO && widx <= W_PRHI) begin
      bus_rdata_o = prio[rd_grp*32 +: 32];
    end else begin
      case (widx)
        W_CTRL: bus_rdata_o = ctrl;
        W_MASK: bus_rdata_o = {27'd0, mask};
        W_ENH:  bus_rdata_o = enable[63:32];
        W_ENL:  bus_rdata_o = enable[31:0];
        W_TYH:  bus_rdata_o = route[63:32];
        W_TYL:  bus_rdata_o = route[31:0];
        W_NVEC: bus_rdata_o = nvec;
        W_FVEC: bus_rdata_o = fvec;
        W_RAWH: bus_rdata_o = src_i[63:32];
        W_RAWL: bus_rdata_o = src_i[31:0];
        W_FRCH: bus_rdata_o = frc[63:32];
        W_FRCL: bus_rdata_o = frc[31:0];
        W_NPH:  bus_rdata_o = npend[63:32];
        W_NPL:  bus_rdata_o = npend[31:0];
        W_FPH:  bus_rdata_o = fpend[63:32];
        W_FPL:  bus_rdata_o = fpend[31:0];
        default: bus_rdata_o = '0;
      endcase
    end
  end

  // R8: fast vector names a fast-pending source
  p_fvec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_any |-> fpend[fvec[16 +: IDXW]]);
endmodule

// File: tb/prio_vec_intc_tb.sv
`timescale 1ns/1ps
module prio_vec_intc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n, irq_f;

  int total = 0, failed = 0;

  logic [63:0] en_m = '0, ty_m = '0, fr_m = '0;
  int          prio_m [64];
  logic [4:0]  mask_m = 5'h1F;

  always #2.5 clk = ~clk;

  prio_vec_intc u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_norm_o(irq_n), .irq_fast_o(irq_f)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    brd(a, d);
    chk(tag, d, exp);
  endtask

  function automatic logic [31:0] grp_word(input int g);
    logic [31:0] w = '0;
    for (int k = 7; k >= 0; k--) w = (w << 4) | 32'(prio_m[g*8+k] & 15);
    return w;
  endfunction

  task automatic set_prio(input int s, input int p);
    prio_m[s] = p;
    bwr(7'(32'h20 + 4*(7 - s/8)), grp_word(s/8));
  endtask

  task automatic set_en(input logic [63:0] v);
    en_m = v; bwr(7'h10, v[63:32]); bwr(7'h14, v[31:0]);
  endtask
  task automatic set_ty(input logic [63:0] v);
    ty_m = v; bwr(7'h18, v[63:32]); bwr(7'h1C, v[31:0]);
  endtask
  task automatic set_fr(input logic [63:0] v);
    fr_m = v; bwr(7'h50, v[63:32]); bwr(7'h54, v[31:0]);
  endtask
  task automatic set_mask(input logic [4:0] m);
    mask_m = m; bwr(7'h04, {27'd0, m});
  endtask

  function automatic logic [63:0] exp_np();
    return (src | fr_m) & en_m & ~ty_m;
  endfunction
  function automatic logic [63:0] exp_fp();
    return (src | fr_m) & en_m & ty_m;
  endfunction

  // scan downward, strictly greater: the higher number keeps a tie
  function automatic logic [31:0] exp_nvec(output int bp);
    logic [63:0] p = exp_np();
    int best = -1;
    bp = -1;
    for (int s = 63; s >= 0; s--) if (p[s] && prio_m[s] > bp) begin best = s; bp = prio_m[s]; end
    if (best < 0) return 32'hFFFF_FFFF;
    return {16'(best), 16'(bp)};
  endfunction
  function automatic logic [31:0] exp_fvec();
    logic [63:0] p = exp_fp();
    for (int s = 63; s >= 0; s--) if (p[s]) return {16'(s), 16'd0};
    return 32'hFFFF_FFFF;
  endfunction
  function automatic logic exp_irqn();
    int bp;
    logic [31:0] v = exp_nvec(bp);
    if (v == 32'hFFFF_FFFF || mask_m == 5'h1F) return 1'b0;
    if (mask_m >= 5'h10) return 1'b1;
    return bp > int'(mask_m);
  endfunction

  task automatic state_chk(input string tag);
    int bp;
    logic [63:0] np = exp_np(), fp = exp_fp();
    rd_chk({tag, " R6 npend hi"}, 7'h58, np[63:32]);
    rd_chk({tag, " R6 npend lo"}, 7'h5C, np[31:0]);
    rd_chk({tag, " R6 fpend hi"}, 7'h60, fp[63:32]);
    rd_chk({tag, " R6 fpend lo"}, 7'h64, fp[31:0]);
    rd_chk({tag, " R7 nvec"}, 7'h40, exp_nvec(bp));
    rd_chk({tag, " R8 fvec"}, 7'h44, exp_fvec());
    @(negedge clk);
    chk({tag, " R9 irq_norm"}, {31'd0, irq_n}, {31'd0, exp_irqn()});
    chk({tag, " R10 irq_fast"}, {31'd0, irq_f}, {31'd0, |fp});
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 7'h00, 32'd0);
    rd_chk("R1 mask", 7'h04, 32'h1F);
    for (int a = 'h10; a <= 'h1C; a += 4) rd_chk("R1 en/type", 7'(a), 32'd0);
    rd_chk("R1 force hi", 7'h50, 32'd0);
    rd_chk("R1 force lo", 7'h54, 32'd0);
    for (int a = 'h20; a <= 'h3C; a += 4) rd_chk("R1 prio", 7'(a), 32'd0);
    chk("R1 irq_norm", {31'd0, irq_n}, 32'd0);
    chk("R1 irq_fast", {31'd0, irq_f}, 32'd0);
  endtask

  task automatic t_en_num();
    bwr(7'h08, 32'd5); bwr(7'h08, 32'd40); bwr(7'h08, 32'd63);
    rd_chk("R2 set lo", 7'h14, 32'h0000_0020);
    rd_chk("R2 set hi", 7'h10, 32'h8000_0100);
    bwr(7'h0C, 32'd5);
    rd_chk("R2 clr lo", 7'h14, 32'd0);
    rd_chk("R2 clr keeps hi", 7'h10, 32'h8000_0100);
    bwr(7'h0C, 32'd63);
    rd_chk("R2 clr hi", 7'h10, 32'h0000_0100);
    en_m = 64'h0000_0100_0000_0000;
  endtask

  task automatic t_range();
    bwr(7'h08, 32'd64); bwr(7'h08, 32'd67); bwr(7'h0C, 32'd72); bwr(7'h0C, 32'hFFFF_FFFF);
    rd_chk("R3 hi unchanged", 7'h10, 32'h0000_0100);
    rd_chk("R3 lo unchanged", 7'h14, 32'd0);
  endtask

  task automatic t_maps();
    bwr(7'h10, 32'hA5A5_0001); rd_chk("R4 en hi", 7'h10, 32'hA5A5_0001);
    bwr(7'h1C, 32'h1234_5678); rd_chk("R4 type lo", 7'h1C, 32'h1234_5678);
    bwr(7'h50, 32'h0F0F_F0F0); rd_chk("R4 force hi", 7'h50, 32'h0F0F_F0F0);
    rd_chk("R4 en lo untouched", 7'h14, 32'd0);
    set_en('0); set_ty('0); set_fr('0);
  endtask

  task automatic t_prio();
    bwr(7'h20, 32'h7654_3210);
    rd_chk("R5 group7 at 0x20", 7'h20, 32'h7654_3210);
    rd_chk("R5 group0 at 0x3C", 7'h3C, 32'd0);
    for (int k = 0; k < 8; k++) prio_m[56+k] = k;
    set_prio(3, 10);
    rd_chk("R5 source3 bits 15:12", 7'h3C, 32'h0000_A000);
    // source 60 (prio 4) alone enabled: vector reports prio field from group 7
    src = 64'h1000_0000_0000_0000; set_en(64'h1000_0000_0000_0000);
    rd_chk("R5 R7 prio of source 60", 7'h40, {16'd60, 16'd4});
    set_en('0); src = '0;
    for (int k = 0; k < 8; k++) prio_m[56+k] = 0;
    bwr(7'h20, 32'd0);
  endtask

  task automatic t_nvec();
    set_mask(5'd0);
    set_prio(10, 9); set_prio(20, 9); set_prio(3, 5);
    src = (64'd1 << 3) | (64'd1 << 10) | (64'd1 << 20);
    set_en(src);
    state_chk("tie high wins");
    set_prio(10, 12);
    state_chk("higher prio wins");
    set_fr(64'd1 << 45); set_prio(45, 12); set_en(en_m | (64'd1 << 45));
    state_chk("force raises 45");
    set_en('0);
    state_chk("none pending");
  endtask

  task automatic t_fvec();
    set_ty((64'd1 << 7) | (64'd1 << 50) | (64'd1 << 10));
    src = src | (64'd1 << 7);
    set_en((64'd1 << 7) | (64'd1 << 10) | (64'd1 << 50) | (64'd1 << 20));
    state_chk("fast 7,10");
    set_fr(fr_m | (64'd1 << 50));
    state_chk("fast top 50");
    set_en(en_m & ~((64'd1 << 7) | (64'd1 << 10) | (64'd1 << 50)));
    state_chk("fast off");
  endtask

  task automatic t_mask();
    // winner: source 20, prio 9
    set_mask(5'd9);    state_chk("mask 9 equal");
    rd_chk("R9 mask read", 7'h04, 32'd9);
    set_mask(5'd8);    state_chk("mask 8 below");
    set_mask(5'h10);   state_chk("mask 0x10");
    set_mask(5'h1E);   state_chk("mask 0x1E");
    set_mask(5'h1F);   state_chk("mask 0x1F");
    set_mask(5'd0);
  endtask

  task automatic t_timing();
    set_en('0); set_fr('0); set_ty(64'd1 << 33); src = '0;
    set_prio(2, 1);
    set_en((64'd1 << 2) | (64'd1 << 33));
    @(negedge clk);
    src = (64'd1 << 2) | (64'd1 << 33);
    #1;
    chk("R11 norm not yet", {31'd0, irq_n}, 32'd0);
    chk("R11 fast not yet", {31'd0, irq_f}, 32'd0);
    @(posedge clk); #1;
    chk("R11 norm after one edge", {31'd0, irq_n}, 32'd1);
    chk("R11 fast after one edge", {31'd0, irq_f}, 32'd1);
    @(negedge clk);
    src = '0;
    #1 chk("R11 norm holds until edge", {31'd0, irq_n}, 32'd1);
    @(posedge clk); #1;
    chk("R11 norm drops", {31'd0, irq_n}, 32'd0);
    chk("R11 fast drops", {31'd0, irq_f}, 32'd0);
  endtask

  task automatic t_ro();
    src = 64'd1 << 2;
    for (int a = 'h40; a <= 'h64; a += 4) if (a != 'h50 && a != 'h54) bwr(7'(a), 32'hFFFF_FFFF);
    rd_chk("R12 en hi", 7'h10, en_m[63:32]);
    rd_chk("R12 en lo", 7'h14, en_m[31:0]);
    rd_chk("R12 force lo", 7'h54, 32'd0);
    rd_chk("R12 R6 raw lo", 7'h4C, 32'h0000_0004);
    state_chk("R12 after ro writes");
  endtask

  initial begin
    #(5.0 * 150000);
    failed++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    for (int s = 0; s < 64; s++) prio_m[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_en_num();
    t_range();
    t_maps();
    t_prio();
    t_nvec();
    t_fvec();
    t_mask();
    t_timing();
    t_ro();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule